// File: doc/BRIEF.md
# Context-ID Capturing Link Receiver

This block is the receive side of a logic cell in a multi-context fabric. The fabric carries data and context identifiers on the same wires. Each of two upstream links delivers symbols on three wires: a class bit `c`, a value bit `v` and a toggle bit `r`. A new symbol is recognised when the parity `c ^ v ^ r` of a link changes. The block pairs one symbol from each link. When both carry `c = 0`, the pair goes to the cell's look-up table as two operand bits. When both carry `c = 1`, the value on link A is one bit of a serial context identifier. That bit is shifted into a capture register and acknowledged upstream.

When the last identifier bit is stored, the captured identifier becomes the look-up table's context select. A small transmitter then replays the identifier on the single downstream link, one symbol per cycle. While it does so, no new pair is taken. An output selector places either the look-up result (a data symbol) or the replayed identifier (identifier symbols) on the downstream link. The selector follows the class of the previous accepted pair, so it switches one symbol later than the input does. The whole block is modelled synchronously to one clock.

Top module: `ctxrx_top`

## Requirements
- R1: A link holds a pending symbol while its parity `c^v^r` differs from the parity of the last symbol taken from it. A pair is taken at a clock edge only when both links are pending and the transmitter is idle. A lone pending link is not taken.
- R2: A taken pair with `c = 0` on both links drives `lut_a` (link 0 `v`) and `lut_b` (link 1 `v`) and raises `lut_stb` for one cycle after the edge.
- R3: A taken pair with `c = 1` on both links shifts link 0's `v` into the identifier register, the first bit received becoming the most significant. `ack` is high for one cycle after the edge that stored the bit. Link 1's `v` is ignored.
- R4: `ctx_sel` changes only when the ID_W-th consecutive identifier bit is stored, and takes the full captured value in that same cycle.
- R5: After a complete identifier, the downstream link emits ID_W symbols with `c = 1`, most significant bit first, on consecutive cycles starting one cycle after `ctx_sel` updates. No pair is taken until the last of them is out.
- R6: One cycle after `lut_stb`, the downstream link emits one symbol with `c = 0` and `v = lut_y`.
- R7: A taken pair whose `c` values differ is consumed with no other effect: no strobe, no ack, no output symbol, the operands are held, and a partially captured identifier keeps its bit count.
- R8: A data pair taken before an identifier is complete discards the partial bits. The next identifier needs ID_W fresh bits, and `ctx_sel` is unchanged.
- R9: Every downstream symbol toggles the output parity `out_c^out_v^out_r`.
- R10: While `rst_n` is low at a clock edge, every output clears to 0 and the link parities are taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_c | input | 2 | Class bit per upstream link (index 0 = A, 1 = B) |
| lnk_v | input | 2 | Value bit per upstream link |
| lnk_r | input | 2 | Toggle bit per upstream link |
| lut_y | input | 1 | Result from the external look-up table |
| lut_a | output | 1 | Look-up operand from link A |
| lut_b | output | 1 | Look-up operand from link B |
| lut_stb | output | 1 | One-cycle pulse: new operands presented |
| ack | output | 1 | One-cycle pulse: identifier bit stored |
| ctx_sel | output | ID_W | Captured context identifier |
| out_c | output | 1 | Downstream class bit |
| out_v | output | 1 | Downstream value bit |
| out_r | output | 1 | Downstream toggle bit |

## Verification
A pair presented before edge E shows its effect on `lut_a`, `lut_b`, `lut_stb`, `ack` and `ctx_sel` right after E. The bench therefore drives on a falling edge and reads these outputs on the next falling edge. Output symbols come later: a data symbol appears one edge after its strobe, and identifier replay occupies the edges E+1 to E+ID_W. For that reason the downstream link is not sampled at fixed times. A monitor watches the output parity on every falling edge and compares each new symbol, in order, with a queue that the driver fills when it sends a stimulus. A pair sent during replay is checked to stay untaken for exactly the ID_W cycles of the replay.

// File: rtl/ctxrx_pkg.sv
// Package: shared constants and types for the context-ID link receiver.
// Assumes: exactly two upstream links feed one cell.
package ctxrx_pkg;
    localparam int NLINK = 2;

    // One downstream symbol before the toggle bit is worked out.
    typedef struct packed {
        logic c;
        logic v;
    } sym_t;
endpackage

// File: rtl/ctxrx_link_rx.sv
// Module: ctxrx_link_rx
// Detects a pending symbol on one upstream link by comparing its
// parity with the parity of the last symbol consumed.
// Assumes: upstream holds a symbol stable until it is consumed.
module ctxrx_link_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic c_i,
    input  logic v_i,
    input  logic r_i,
    input  logic take_i,
    output logic pend_o
);
    logic ph_q;
    logic ph_now;

    assign ph_now = c_i ^ v_i ^ r_i;
    assign pend_o = ph_now != ph_q;

    // Remember the parity of the last consumed symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)      ph_q <= 1'b0;
        else if (take_i) ph_q <= ph_now;
    end
endmodule

// File: rtl/ctxrx_id_shift.sv
// Module: ctxrx_id_shift
// Collects a serial context identifier, MSB first. Acknowledges each
// stored bit and publishes the full identifier when the last bit arrives.
// Assumes: ID_W >= 2; clear_i and shift_i are never high together.
module ctxrx_id_shift #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_i,
    input  logic            clear_i,
    input  logic            bit_i,
    output logic            ack_o,
    output logic            full_o,
    output logic [ID_W-1:0] full_id_o,
    output logic [ID_W-1:0] ctx_o
);
    localparam int CNT_W = (ID_W > 2) ? $clog2(ID_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_W - 1);

    logic [ID_W-1:0]  sreg_q;
    logic [CNT_W-1:0] cnt_q;

    assign full_id_o = {sreg_q[ID_W-2:0], bit_i};
    assign full_o    = shift_i && (cnt_q == LAST);

    // Shift register, bit counter and published identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
            ctx_o  <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            sreg_q <= full_id_o;
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                ctx_o <= full_id_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // One-cycle acknowledge after each stored bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_o <= 1'b0;
        else        ack_o <= shift_i;
    end
endmodule

// File: rtl/ctxrx_id_tx.sv
// Module: ctxrx_id_tx
// Replays a captured identifier downstream, MSB first, one bit per cycle.
// Assumes: load_i is only raised while idle (busy_o low).
module ctxrx_id_tx #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [ID_W-1:0] id_i,
    output logic            busy_o,
    output logic            bit_o
);
    localparam int LW = $clog2(ID_W + 1);

    logic [ID_W-1:0] buf_q;
    logic [LW-1:0]   left_q;

    assign busy_o = left_q != '0;
    assign bit_o  = buf_q[ID_W-1];

    // Load on a completed identifier, then shift one bit out per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            buf_q  <= id_i;
            left_q <= LW'(ID_W);
        end else if (busy_o) begin
            buf_q  <= buf_q << 1;
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/ctxrx_out_enc.sv
// Module: ctxrx_out_enc
// Encodes downstream symbols: each fired symbol toggles the output parity.
// Assumes: at most one symbol per cycle.
module ctxrx_out_enc
    import ctxrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  sym_t sym_i,
    output logic c_o,
    output logic v_o,
    output logic r_o
);
    logic ph_next;

    assign ph_next = ~(c_o ^ v_o ^ r_o);

    // Register the symbol and pick r so the parity flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_o <= 1'b0;
            v_o <= 1'b0;
            r_o <= 1'b0;
        end else if (fire_i) begin
            c_o <= sym_i.c;
            v_o <= sym_i.v;
            r_o <= ph_next ^ sym_i.c ^ sym_i.v;
        end
    end
endmodule

// File: rtl/ctxrx_top.sv
// Module: ctxrx_top
// Receive side of a logic cell: pairs symbols from two links, routes data
// to the look-up table, captures serial context identifiers and replays
// them downstream through a selector that lags the input by one symbol.
// Assumes: both links of a pair normally agree on their class bit.
module ctxrx_top
    import ctxrx_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      lnk_c,
    input  logic [1:0]      lnk_v,
    input  logic [1:0]      lnk_r,
    input  logic            lut_y,
    output logic            lut_a,
    output logic            lut_b,
    output logic            lut_stb,
    output logic            ack,
    output logic [ID_W-1:0] ctx_sel,
    output logic            out_c,
    output logic            out_v,
    output logic            out_r
);
    logic [NLINK-1:0] pend;
    logic             take, same_c, data_acc, id_acc;
    logic             tx_busy, tx_bit, id_full, sel_q;
    logic [ID_W-1:0]  full_id;
    sym_t             osym;

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        ctxrx_link_rx u_rx (
            .clk(clk), .rst_n(rst_n),
            .c_i(lnk_c[i]), .v_i(lnk_v[i]), .r_i(lnk_r[i]),
            .take_i(take), .pend_o(pend[i])
        );
    end

    assign take     = (&pend) && !tx_busy;
    assign same_c   = lnk_c[0] == lnk_c[1];
    assign data_acc = take && same_c && !lnk_c[0];
    assign id_acc   = take && same_c &&  lnk_c[0];

    // Look-up operands and their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lut_a   <= 1'b0;
            lut_b   <= 1'b0;
            lut_stb <= 1'b0;
        end else begin
            lut_stb <= data_acc;
            if (data_acc) begin
                lut_a <= lnk_v[0];
                lut_b <= lnk_v[1];
            end
        end
    end

    // Output selector follows the class of the last matching pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sel_q <= 1'b0;
        else if (data_acc || id_acc)   sel_q <= lnk_c[0];
    end

    ctxrx_id_shift #(.ID_W(ID_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_i(id_acc), .clear_i(data_acc), .bit_i(lnk_v[0]),
        .ack_o(ack), .full_o(id_full), .full_id_o(full_id), .ctx_o(ctx_sel)
    );

    ctxrx_id_tx #(.ID_W(ID_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load_i(id_full), .id_i(full_id),
        .busy_o(tx_busy), .bit_o(tx_bit)
    );

    assign osym.c = sel_q;
    assign osym.v = sel_q ? tx_bit : lut_y;

    ctxrx_out_enc u_enc (
        .clk(clk), .rst_n(rst_n),
        .fire_i(lut_stb || tx_busy), .sym_i(osym),
        .c_o(out_c), .v_o(out_v), .r_o(out_r)
    );
endmodule

// File: rtl/ctxrx_checker.sv
// Module: ctxrx_checker
// Temporal properties of ctxrx_top, attached by bind.
module ctxrx_checker #(
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      lnk_c,
    input logic            lut_stb,
    input logic            ack,
    input logic [ID_W-1:0] ctx_sel,
    input logic            out_c,
    input logic            out_v,
    input logic            out_r
);
    logic out_par;
    assign out_par = out_c ^ out_v ^ out_r;

    a_r2_stb_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        lut_stb |-> $past(lnk_c) == 2'b00);

    a_r3_ack_from_id: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(lnk_c) == 2'b11);

    a_r4_ctx_moves_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctx_sel) |-> ack);

    a_r7_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && lut_stb));

    a_r6_data_symbol_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (out_par != $past(out_par)) && !out_c |-> $past(lut_stb));
endmodule

bind ctxrx_top ctxrx_checker #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lnk_c(lnk_c), .lut_stb(lut_stb),
    .ack(ack), .ctx_sel(ctx_sel), .out_c(out_c), .out_v(out_v), .out_r(out_r)
);

// File: tb/ctxrx_top_test.sv
// Scoreboard bench for ctxrx_top: the driver queues expected downstream
// symbols, a monitor pops them as the output parity toggles.
module ctxrx_top_test;
    localparam int CLK_P = 10;
    localparam int ID_W  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      lnk_c = '0, lnk_v = '0, lnk_r = '0;
    logic            lut_y;
    logic            lut_a, lut_b, lut_stb, ack;
    logic [ID_W-1:0] ctx_sel;
    logic            out_c, out_v, out_r;

    int        checks = 0;
    int        errors = 0;
    logic [1:0] par = '0;
    logic [1:0] expq[$];
    logic       mon_on = 1'b0;
    logic       prev_par = 1'b0;
    logic       done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign lut_y = lut_a ^ lut_b;   // external table model

    ctxrx_top #(.ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .lnk_c(lnk_c), .lnk_v(lnk_v), .lnk_r(lnk_r),
        .lut_y(lut_y), .lut_a(lut_a), .lut_b(lut_b), .lut_stb(lut_stb),
        .ack(ack), .ctx_sel(ctx_sel), .out_c(out_c), .out_v(out_v), .out_r(out_r)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int i, input logic c, input logic v);
        par[i]   = ~par[i];
        lnk_c[i] = c;
        lnk_v[i] = v;
        lnk_r[i] = par[i] ^ c ^ v;
    endtask

    // Present a pair and move to the falling edge after the taking edge.
    task automatic send(input logic c0, input logic v0, input logic c1, input logic v1);
        drive(0, c0, v0);
        drive(1, c1, v1);
        @(negedge clk);
    endtask

    task automatic send_data(input logic a, input logic b);
        send(1'b0, a, 1'b0, b);
        chk(lut_stb == 1'b1, "R2 stb", lut_stb, 1);
        chk({lut_a, lut_b} == {a, b}, "R2 operands", {lut_a, lut_b}, {a, b});
        chk(ack == 1'b0, "R2 no ack", ack, 0);
        expq.push_back({1'b0, a ^ b});
    endtask

    task automatic send_id(input logic b);
        send(1'b1, b, 1'b1, ~b);   // link B value is ignored
        chk(ack == 1'b1, "R3 ack", ack, 1);
        chk(lut_stb == 1'b0, "R3 no stb", lut_stb, 0);
    endtask

    task automatic expect_id(input logic [ID_W-1:0] id);
        for (int k = ID_W - 1; k >= 0; k--) expq.push_back({1'b1, id[k]});
    endtask

    // Monitor: every toggle of the output parity is one symbol (R5, R6, R9).
    always @(negedge clk) begin
        if (mon_on && ((out_c ^ out_v ^ out_r) != prev_par)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected symbol", {out_c, out_v}, 0);
            end else begin
                logic [1:0] e;
                e = expq.pop_front();
                chk({out_c, out_v} == e, e[1] ? "R5 id symbol" : "R6 data symbol",
                    {out_c, out_v}, e);
            end
        end
        prev_par = out_c ^ out_v ^ out_r;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({lut_a, lut_b, lut_stb, ack} == 4'b0, "R10 lut/ack", {lut_a, lut_b, lut_stb, ack}, 0);
        chk(ctx_sel == '0, "R10 ctx", ctx_sel, 0);
        chk({out_c, out_v, out_r} == 3'b0, "R10 out", {out_c, out_v, out_r}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R2, R6: data pairs of several patterns
        send_data(1'b1, 1'b0);
        send_data(1'b1, 1'b1);
        send_data(1'b0, 1'b1);
        send_data(1'b0, 1'b0);

        // R3, R4, R5: identifier 101
        send_id(1'b1);
        send_id(1'b0);
        chk(ctx_sel == '0, "R4 ctx before last bit", ctx_sel, 0);
        send_id(1'b1);
        chk(ctx_sel == 3'd5, "R4 ctx complete", ctx_sel, 5);
        expect_id(3'd5);
        repeat (3) @(negedge clk);

        // R8: partial identifier dropped by a data pair
        send_id(1'b1);
        send_id(1'b1);
        send_data(1'b1, 1'b0);
        send_id(1'b0);
        chk(ctx_sel == 3'd5, "R8 ctx kept after restart bit", ctx_sel, 5);
        send_id(1'b1);
        chk(ctx_sel == 3'd5, "R8 ctx needs fresh bits", ctx_sel, 5);
        send_id(1'b1);
        chk(ctx_sel == 3'd3, "R8 ctx fresh id", ctx_sel, 3);
        expect_id(3'd3);
        repeat (3) @(negedge clk);

        // R7: mismatched pairs consumed with no effect
        send_data(1'b1, 1'b1);
        send_id(1'b1);
        send_id(1'b1);
        send(1'b1, 1'b0, 1'b0, 1'b0);
        chk({lut_stb, ack} == 2'b00, "R7 no stb/ack", {lut_stb, ack}, 0);
        chk({lut_a, lut_b} == 2'b11, "R7 operands held", {lut_a, lut_b}, 3);
        send(1'b0, 1'b0, 1'b1, 1'b0);
        chk({lut_stb, ack} == 2'b00, "R7 no stb/ack 2", {lut_stb, ack}, 0);
        chk(ctx_sel == 3'd3, "R7 ctx held", ctx_sel, 3);
        send_id(1'b0);
        chk(ctx_sel == 3'd6, "R7 count held", ctx_sel, 6);
        expect_id(3'd6);
        repeat (3) @(negedge clk);

        // R1: a lone pending link is not taken
        drive(0, 1'b0, 1'b1);
        @(negedge clk);
        chk(lut_stb == 1'b0, "R1 lone link", lut_stb, 0);
        @(negedge clk);
        chk(lut_stb == 1'b0, "R1 lone link hold", lut_stb, 0);
        drive(1, 1'b0, 1'b0);
        @(negedge clk);
        chk(lut_stb == 1'b1, "R1 pair joined", lut_stb, 1);
        chk({lut_a, lut_b} == 2'b10, "R1 operands", {lut_a, lut_b}, 2);
        expq.push_back(2'b01);

        // R5: pair held off during replay of identifier 010
        send_id(1'b0);
        send_id(1'b1);
        send_id(1'b0);
        chk(ctx_sel == 3'd2, "R4 ctx 010", ctx_sel, 2);
        expect_id(3'd2);
        drive(0, 1'b0, 1'b1);
        drive(1, 1'b0, 1'b1);
        for (int k = 0; k < ID_W; k++) begin
            @(negedge clk);
            chk(lut_stb == 1'b0, "R5 stalled during replay", lut_stb, 0);
        end
        @(negedge clk);
        chk(lut_stb == 1'b1, "R5 taken after replay", lut_stb, 1);
        chk({lut_a, lut_b} == 2'b11, "R5 operands", {lut_a, lut_b}, 3);
        expq.push_back(2'b00);

        repeat (6) @(negedge clk);
        chk(expq.size() == 0, "R9 all symbols seen", expq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule